// File: doc/BRIEF.md
# Variable-Size Cyclic Shift Network

This block lines up a vector of message lanes with the cyclic offset of one square submatrix of a quasi-cyclic parity-check code. Each transfer carries a full-width vector of lanes, a lifting size Z chosen at runtime, a shift amount and a direction flag. Only the lowest Z lanes take part in the rotation, and the rotation wraps modulo Z rather than modulo the physical lane count. Every lane at or above Z leaves the block as zero. The inverse direction applies the opposite rotation, so that a message vector read in one orientation can be put back in the other on write-back.

The block is a registered datapath with no stalls. One transfer can enter on every clock, and the lifting size, shift and direction may differ from one transfer to the next without any setup cycles. The result appears a fixed number of cycles later together with its valid flag. Internally the datapath reduces the shift, masks off the unused lanes, and then performs two logarithmic shifts, one toward higher lanes and one toward lower lanes. Their results are merged and masked to Z.

Top module: `cyc_shift_net`

## Requirements
- R1: With in_inverse=0, input lane i (bits i*W+W-1..i*W) for i < Z appears at output lane (i + s) mod Z, where s is the reduced shift amount.
- R2: With in_inverse=1, input lane i for i < Z appears at output lane (i - s) mod Z.
- R3: Output lanes with index at or above Z are zero, and input lanes at or above Z have no effect on the output.
- R4: A shift amount at or above Z is reduced modulo Z before use. For example, a shift equal to Z gives the identity.
- R5: Z, the shift and the direction are taken independently on every transfer, and back-to-back transfers are each rotated with their own values at a rate of one per clock.
- R6: out_valid equals in_valid delayed by exactly 3 clock cycles.
- R7: out_lanes is all zero on every cycle where out_valid is 0, whatever data was present on in_lanes.
- R8: An in_z of 0 yields an all-zero output vector with out_valid still set. An in_z above LANES is treated as LANES.
- R9: While rst_n is low and on the first cycles after it rises, out_valid is 0 and out_lanes is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transfer present on the inputs this cycle |
| in_lanes | input | LANES*W | Input message lanes, lane i at bits i*W upward |
| in_z | input | ZW = clog2(LANES+1) | Runtime lifting size |
| in_shift | input | ZW | Cyclic shift amount, any value |
| in_inverse | input | 1 | 0 rotates toward higher lanes, 1 toward lower lanes |
| out_valid | output | 1 | Result present on out_lanes |
| out_lanes | output | LANES*W | Rotated lanes, zero at and above Z |

## Verification
The checker compares the outputs with inputs that it has delayed three cycles itself. It therefore assumes that in_valid is held low while reset is asserted, so that a transfer is never half-captured during reset. The bench drives every input on the falling edge and keeps in_valid low throughout reset. Otherwise the assertions make no assumption about the inputs: any Z, including 0 and values above LANES, and any shift width value are legal. The stimulus deliberately covers those values, and it also covers non-zero data in the unused upper lanes and non-zero data while in_valid is low.

// File: rtl/csn_pkg.sv
package csn_pkg;

  // Lifting size limited to the physical lane count.
  function automatic logic [15:0] clamp_z(input logic [15:0] z, input logic [15:0] lanes);
    return (z > lanes) ? lanes : z;
  endfunction

  // Remainder of s divided by z by restoring division; z must be non-zero.
  function automatic logic [15:0] mod_reduce(input logic [15:0] s, input logic [15:0] z);
    logic [16:0] rem;
    rem = '0;
    for (int b = 15; b >= 0; b--) begin
      rem = {rem[15:0], s[b]};
      if (rem >= {1'b0, z}) rem = rem - {1'b0, z};
    end
    return rem[15:0];
  endfunction

  // The inverse rotation by s equals a forward rotation by z - s.
  function automatic logic [15:0] eff_shift(input logic [15:0] s_red, input logic [15:0] z,
                                            input logic inv);
    return (inv && s_red != 16'd0) ? (z - s_red) : s_red;
  endfunction

endpackage

// File: rtl/csn_prep.sv
module csn_prep #(
  parameter int LANES = 384,
  parameter int W     = 8,
  localparam int ZW   = $clog2(LANES + 1),
  localparam int VW   = LANES * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] in_lanes,
  input  logic [ZW-1:0] in_z,
  input  logic [ZW-1:0] in_shift,
  input  logic          in_inverse,
  output logic          a_valid,
  output logic [VW-1:0] a_lanes,
  output logic [ZW-1:0] a_z,
  output logic [ZW-1:0] a_lsh,
  output logic [ZW-1:0] a_rsh
);
  logic [ZW-1:0] z_clamped;
  logic [ZW-1:0] s_reduced;
  logic [ZW-1:0] s_eff;
  logic [VW-1:0] lanes_masked;

  assign z_clamped = ZW'(csn_pkg::clamp_z(16'(in_z), 16'(LANES)));
  assign s_reduced = (z_clamped == '0) ? '0
                   : ZW'(csn_pkg::mod_reduce(16'(in_shift), 16'(z_clamped)));
  assign s_eff     = ZW'(csn_pkg::eff_shift(16'(s_reduced), 16'(z_clamped), in_inverse));

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lanes_masked[i*W +: W] = (in_valid && (ZW'(i) < z_clamped)) ? in_lanes[i*W +: W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_lanes <= '0;
      a_z     <= '0;
      a_lsh   <= '0;
      a_rsh   <= '0;
    end else begin
      a_valid <= in_valid;
      a_lanes <= lanes_masked;
      a_z     <= z_clamped;
      a_lsh   <= s_eff;
      a_rsh   <= z_clamped - s_eff;
    end
  end
endmodule

// File: rtl/csn_logshift.sv
module csn_logshift #(
  parameter int LANES = 384,
  parameter int W     = 8,
  parameter bit UP    = 1'b1,
  localparam int ZW   = $clog2(LANES + 1),
  localparam int VW   = LANES * W
) (
  input  logic [VW-1:0] vec_in,
  input  logic [ZW-1:0] amount,
  output logic [VW-1:0] vec_out
);
  logic [VW-1:0] stg [ZW+1];

  assign stg[0] = vec_in;
  for (genvar k = 0; k < ZW; k++) begin : g_stage
    localparam int STEP = W * (1 << k);
    if (UP) begin : g_up
      assign stg[k+1] = amount[k] ? (stg[k] << STEP) : stg[k];
    end else begin : g_down
      assign stg[k+1] = amount[k] ? (stg[k] >> STEP) : stg[k];
    end
  end
  assign vec_out = stg[ZW];
endmodule

// File: rtl/csn_merge.sv
module csn_merge #(
  parameter int LANES = 384,
  parameter int W     = 8,
  localparam int ZW   = $clog2(LANES + 1),
  localparam int VW   = LANES * W
) (
  input  logic          b_valid,
  input  logic [VW-1:0] up_part,
  input  logic [VW-1:0] down_part,
  input  logic [ZW-1:0] b_z,
  output logic [VW-1:0] merged
);
  logic [VW-1:0] joined;
  assign joined = up_part | down_part;

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign merged[i*W +: W] = (b_valid && (ZW'(i) < b_z)) ? joined[i*W +: W] : '0;
  end
endmodule

// File: rtl/cyc_shift_net.sv
module cyc_shift_net #(
  parameter int LANES = 384,
  parameter int W     = 8,
  localparam int ZW   = $clog2(LANES + 1),
  localparam int VW   = LANES * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] in_lanes,
  input  logic [ZW-1:0] in_z,
  input  logic [ZW-1:0] in_shift,
  input  logic          in_inverse,
  output logic          out_valid,
  output logic [VW-1:0] out_lanes
);
  // Stage A: reduced shift, masked lanes
  logic          a_valid;
  logic [VW-1:0] a_lanes;
  logic [ZW-1:0] a_z, a_lsh, a_rsh;
  // Stage B: the two partial rotations
  logic [VW-1:0] up_comb, down_comb;
  logic          b_valid;
  logic [VW-1:0] b_up, b_down;
  logic [ZW-1:0] b_z;
  logic [VW-1:0] merged;

  csn_prep #(.LANES(LANES), .W(W)) u_prep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
    .in_z(in_z), .in_shift(in_shift), .in_inverse(in_inverse),
    .a_valid(a_valid), .a_lanes(a_lanes), .a_z(a_z), .a_lsh(a_lsh), .a_rsh(a_rsh)
  );

  csn_logshift #(.LANES(LANES), .W(W), .UP(1'b1)) u_up (
    .vec_in(a_lanes), .amount(a_lsh), .vec_out(up_comb)
  );

  csn_logshift #(.LANES(LANES), .W(W), .UP(1'b0)) u_down (
    .vec_in(a_lanes), .amount(a_rsh), .vec_out(down_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_up    <= '0;
      b_down  <= '0;
      b_z     <= '0;
    end else begin
      b_valid <= a_valid;
      b_up    <= up_comb;
      b_down  <= down_comb;
      b_z     <= a_z;
    end
  end

  csn_merge #(.LANES(LANES), .W(W)) u_merge (
    .b_valid(b_valid), .up_part(b_up), .down_part(b_down), .b_z(b_z), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
    end else begin
      out_valid <= b_valid;
      out_lanes <= merged;
    end
  end
endmodule

// File: rtl/cyc_shift_net_chk.sv
module cyc_shift_net_chk #(
  parameter int LANES = 384,
  parameter int W     = 8,
  localparam int ZW   = $clog2(LANES + 1),
  localparam int VW   = LANES * W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [VW-1:0] in_lanes,
  input logic [ZW-1:0] in_z,
  input logic [ZW-1:0] in_shift,
  input logic          out_valid,
  input logic [VW-1:0] out_lanes
);
  logic [1:0]    cyc;
  logic          v_d1, v_d2, v_d3;
  logic [ZW-1:0] z_d1, z_d2, z_d3;
  logic [ZW-1:0] s_d1, s_d2, s_d3;
  logic [VW-1:0] l_d1, l_d2, l_d3;
  logic          upper_nz;
  logic          full_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      {v_d1, v_d2, v_d3} <= '0;
      {z_d1, z_d2, z_d3} <= '0;
      {s_d1, s_d2, s_d3} <= '0;
      {l_d1, l_d2, l_d3} <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      v_d1 <= in_valid; v_d2 <= v_d1; v_d3 <= v_d2;
      z_d1 <= in_z;     z_d2 <= z_d1; z_d3 <= z_d2;
      s_d1 <= in_shift; s_d2 <= s_d1; s_d3 <= s_d2;
      l_d1 <= in_lanes; l_d2 <= l_d1; l_d3 <= l_d2;
    end
  end

  assign full_window = (cyc == 2'd3);

  always_comb begin
    upper_nz = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (i >= int'(z_d3) && out_lanes[i*W +: W] != '0) upper_nz = 1'b1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    full_window |-> (out_valid == v_d3)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_lanes == '0)); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (full_window && out_valid) |-> !upper_nz); // R3

  AST_EMPTY_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (full_window && out_valid && z_d3 == '0) |-> (out_lanes == '0)); // R8

  AST_ZERO_SHIFT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_window && out_valid && int'(z_d3) >= LANES && s_d3 == '0)
      |-> (out_lanes == l_d3)); // R1

  AST_FULL_SHIFT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_window && out_valid && int'(z_d3) == LANES && int'(s_d3) == LANES)
      |-> (out_lanes == l_d3)); // R4
endmodule

bind cyc_shift_net cyc_shift_net_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
  .in_z(in_z), .in_shift(in_shift), .out_valid(out_valid), .out_lanes(out_lanes)
);

// File: tb/tb_cyc_shift_net.sv
module tb_cyc_shift_net;
  localparam int LANES = 24;
  localparam int W     = 6;
  localparam int ZW    = $clog2(LANES + 1);
  localparam int VW    = LANES * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_lanes = '0;
  logic [ZW-1:0] in_z = '0;
  logic [ZW-1:0] in_shift = '0;
  logic          in_inverse = 1'b0;
  logic          out_valid;
  logic [VW-1:0] out_lanes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  // Expected results, one entry per clock, three deep
  logic          pv_v [1:3];
  logic [VW-1:0] pv_d [1:3];
  string         pv_r [1:3];

  always #10 clk = ~clk;

  cyc_shift_net #(.LANES(LANES), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
    .in_z(in_z), .in_shift(in_shift), .in_inverse(in_inverse),
    .out_valid(out_valid), .out_lanes(out_lanes)
  );

  function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input int z, input int s,
                                          input bit inv);
    logic [VW-1:0] r;
    int zc, sr, dst;
    r  = '0;
    zc = (z > LANES) ? LANES : z;
    if (zc == 0) return r;
    sr = s % zc;
    for (int i = 0; i < zc; i++) begin
      dst = inv ? (i + zc - sr) % zc : (i + sr) % zc;
      r[dst*W +: W] = d[i*W +: W];
    end
    return r;
  endfunction

  initial begin
    for (int k = 1; k <= 3; k++) begin pv_v[k] = 1'b0; pv_d[k] = '0; pv_r[k] = "R9"; end
  end

  always @(posedge clk) begin
    pv_v[3] = pv_v[2]; pv_d[3] = pv_d[2]; pv_r[3] = pv_r[2];
    pv_v[2] = pv_v[1]; pv_d[2] = pv_d[1]; pv_r[2] = pv_r[1];
    if (!rst_n || !in_valid) begin
      pv_v[1] = 1'b0; pv_d[1] = '0;
    end else begin
      pv_v[1] = 1'b1;
      pv_d[1] = model(in_lanes, int'(in_z), int'(in_shift), in_inverse);
    end
    pv_r[1] = cur_req;
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== pv_v[3] || out_lanes !== pv_d[3]) begin
        errors++;
        $display("FAIL %s out_valid=%0b out_lanes=%h expected valid=%0b lanes=%h",
                 pv_r[3], out_valid, out_lanes, pv_v[3], pv_d[3]);
      end
    end
  end

  function automatic logic [VW-1:0] pattern(input int seed);
    logic [VW-1:0] p;
    for (int i = 0; i < LANES; i++) p[i*W +: W] = W'((i * 5 + seed) % 63 + 1);
    return p;
  endfunction

  task automatic send(input int z, input int s, input bit inv, input logic [VW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_z = ZW'(z); in_shift = ZW'(s); in_inverse = inv; in_lanes = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_lanes = '0;
    end
  endtask

  initial begin
    // R9: reset state observed by the per-cycle comparison
    cur_req = "R9";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: forward rotation
    cur_req = "R1";
    send(24, 0, 0, pattern(1));
    send(24, 5, 0, pattern(2));
    send(7, 3, 0, pattern(3));
    send(13, 12, 0, pattern(4));
    send(1, 0, 0, pattern(5));
    idle(4);

    // R2: inverse rotation
    cur_req = "R2";
    send(24, 5, 1, pattern(6));
    send(7, 3, 1, pattern(7));
    send(13, 1, 1, pattern(8));
    send(2, 1, 1, pattern(9));
    idle(4);

    // R3: upper input lanes filled, must not reach the output
    cur_req = "R3";
    send(10, 4, 0, {VW{1'b1}});
    send(10, 4, 1, pattern(10));
    send(23, 22, 0, {VW{1'b1}});
    idle(4);

    // R4: shift at or above Z
    cur_req = "R4";
    send(5, 31, 0, pattern(11));
    send(24, 24, 0, pattern(12));
    send(17, 20, 1, pattern(13));
    send(3, 3, 1, pattern(14));
    idle(4);

    // R8: empty and oversized lifting size
    cur_req = "R8";
    send(0, 7, 0, pattern(15));
    send(31, 9, 0, pattern(16));
    send(25, 30, 1, pattern(17));
    idle(4);

    // R6: isolated transfers separated by gaps
    cur_req = "R6";
    send(24, 1, 0, pattern(18));
    idle(2);
    send(9, 2, 0, pattern(19));
    idle(5);

    // R7: data present while in_valid is low
    cur_req = "R7";
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_z = 5'd24; in_shift = ZW'(k); in_lanes = pattern(20 + k);
    end
    idle(4);

    // R5: random parameters on every back-to-back transfer
    cur_req = "R5";
    for (int k = 0; k < 300; k++) begin
      logic [VW-1:0] d;
      for (int i = 0; i < LANES; i++) d[i*W +: W] = W'($urandom);
      send(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 1'($urandom), d);
    end
    idle(5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule